// File: doc/BRIEF.md
# Flash Status Poller

This block sits on the host side of an external flash device. After the host has written a program or erase command sequence, it starts this block to wait for that operation to finish. The block repeatedly reads one address that is valid for the operation through a synchronous memory read port. For programming, that address is the programmed location. For erase, it is any address inside a sector chosen for erasure.

On each status read, the block compares the most significant data bit (bit 7) with the value expected at completion. For a program operation, that value is the top bit of the byte that was programmed. For an erase, it is 1. If bit 7 does not match, the block looks at the time-limit flag (bit 5). When that flag is clear, it keeps polling. When it is set, the block makes exactly one confirming read: a match on that read still counts as success, and a mismatch ends the operation as a failure.

The lower data bits may settle later than bit 7. For that reason, a successful outcome is always followed by one more read, and the returned word becomes the final data. A programmable number of idle clock cycles separates each read from the one before it.

Top module: `fpc_poll_ctrl`

## Requirements
- R1: `start` is accepted only while `busy` is low. `busy` is high in the cycle after an accepted start and stays high until the result. A `start` seen while `busy` is high has no effect on the address read or on the outcome.
- R2: Every read presents the address latched at the accepted start. Once raised, `rd_req` stays high with `rd_addr` unchanged until the cycle in which `rd_ack` is high. That cycle is the handshake, and `rd_data` holds the word in the cycle after it.
- R3: The expected bit 7 is 1 for an erase (`op_is_erase`=1), whatever `expect_msb` is. For a program, it equals `expect_msb`.
- R4: When bit 7 of a status read matches, the block issues one more read. It then reports pass, and `final_data` holds the word from that extra read, not the status word.
- R5: A status read with bit 7 mismatched and bit 5 equal to 0 is followed by another status read.
- R6: A status read with bit 7 mismatched and bit 5 equal to 1 is followed by one recheck read. If bit 7 matches on the recheck, the block behaves as in R4.
- R7: If the recheck read mismatches on bit 7, the block reports fail with `final_data` equal to the recheck word, and issues no further reads.
- R8: With `gap_cycles`=G latched at start, `rd_req` for the next read rises exactly G+1 cycles after the cycle in which the previous read's data was returned.
- R9: `done` is high for exactly one cycle, which is the first cycle with `busy` low. In that cycle exactly one of `pass` and `fail` is high, and neither is high at any other time.
- R10: Bit 5 is not considered when bit 7 matches: a matching status word with bit 5 set still leads to the final read and a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (accepted when idle) |
| op_is_erase | input | 1 | 1 = erase operation, 0 = program |
| expect_msb | input | 1 | Bit 7 of the byte being programmed |
| poll_addr | input | ADDR_W | Valid address for status reads |
| gap_cycles | input | GAP_W | Idle cycles inserted before each read after the first |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Success flag, valid with done |
| fail | output | 1 | Failure flag, valid with done |
| final_data | output | DATA_W | Word from the last read of the operation |
| rd_req | output | 1 | Read request (valid) |
| rd_addr | output | ADDR_W | Read address, stable while rd_req waits |
| rd_ack | input | 1 | Read accepted (ready) |
| rd_data | input | DATA_W | Read word, returned the cycle after the handshake |

## Verification
The assertions assume that the memory side follows the one-cycle return rule. They also assume that `rd_ack` pulsing while `rd_req` is low has no meaning, and that the gap checker sees the same `gap_cycles` value that the block latched when start was accepted. The bench's memory model accepts a request only while `rd_req` is high, after a configurable number of wait cycles. It registers the scripted word on the handshake edge and holds it until the next handshake. The bench changes `gap_cycles` and the other operation inputs only while the block is idle, apart from the deliberate start pulse given while busy.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_GAP  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    RK_POLL    = 2'd0,
    RK_RECHECK = 2'd1,
    RK_FINAL   = 2'd2
  } read_kind_e;
endpackage

// File: rtl/fpc_status_eval.sv
module fpc_status_eval (
  input  logic status_bit,
  input  logic limit_bit,
  input  logic expect_bit,
  output logic matched,
  output logic limit_hit
);
  // Bit 7 decides completion; the limit flag only matters on a mismatch.
  assign matched   = (status_bit == expect_bit);
  assign limit_hit = limit_bit && !matched;
endmodule

// File: rtl/fpc_gap_timer.sv
module fpc_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic             last
);
  localparam logic [GAP_W-1:0] ONE = GAP_W'(1);

  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  assign last = (cnt == ONE);
endmodule

// File: rtl/fpc_read_port.sv
module fpc_read_port #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              issue,
  input  logic              rd_ack,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              accepted
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_load) begin
      addr_q <= addr_in;
    end
  end

  assign rd_req   = issue;
  assign rd_addr  = addr_q;
  assign accepted = issue && rd_ack;
endmodule

// File: rtl/fpc_poll_ctrl.sv
module fpc_poll_ctrl
  import fpc_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int GAP_W     = 8,
  parameter int MATCH_BIT = 7,
  parameter int LIMIT_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_is_erase,
  input  logic              expect_msb,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic [GAP_W-1:0]  gap_cycles,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [DATA_W-1:0] final_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data
);
  seq_state_e       st;
  read_kind_e       kind;
  logic             exp_bit_q;
  logic [GAP_W-1:0] gap_q;
  logic             done_q, pass_q, fail_q;
  logic [DATA_W-1:0] final_q;

  logic accept_start, issue, accepted;
  logic matched, limit_hit;
  logic gap_load, gap_last, gap_zero;
  seq_state_e after_read;

  assign accept_start = start && (st == ST_IDLE);
  assign issue        = (st == ST_REQ);
  assign gap_zero     = (gap_q == '0);
  assign after_read   = gap_zero ? ST_REQ : ST_GAP;
  assign gap_load     = (st == ST_WAIT) && !gap_zero;

  fpc_read_port #(.ADDR_W(ADDR_W)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_load(accept_start),
    .addr_in  (poll_addr),
    .issue    (issue),
    .rd_ack   (rd_ack),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .accepted (accepted)
  );

  fpc_status_eval u_eval (
    .status_bit(rd_data[MATCH_BIT]),
    .limit_bit (rd_data[LIMIT_BIT]),
    .expect_bit(exp_bit_q),
    .matched   (matched),
    .limit_hit (limit_hit)
  );

  fpc_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .load_val(gap_q),
    .last    (gap_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      kind      <= RK_POLL;
      exp_bit_q <= 1'b0;
      gap_q     <= '0;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      fail_q    <= 1'b0;
      final_q   <= '0;
    end else begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept_start) begin
            exp_bit_q <= op_is_erase | expect_msb;
            gap_q     <= gap_cycles;
            kind      <= RK_POLL;
            st        <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (accepted) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (kind == RK_FINAL) begin
            final_q <= rd_data;
            done_q  <= 1'b1;
            pass_q  <= 1'b1;
            st      <= ST_IDLE;
          end else if (matched) begin
            kind <= RK_FINAL;
            st   <= after_read;
          end else if (kind == RK_RECHECK) begin
            final_q <= rd_data;
            done_q  <= 1'b1;
            fail_q  <= 1'b1;
            st      <= ST_IDLE;
          end else begin
            kind <= limit_hit ? RK_RECHECK : RK_POLL;
            st   <= after_read;
          end
        end
        ST_GAP: begin
          if (gap_last) st <= ST_REQ;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st != ST_IDLE);
  assign done       = done_q;
  assign pass       = pass_q;
  assign fail       = fail_q;
  assign final_data = final_q;
endmodule

// File: rtl/fpc_poll_checker.sv
module fpc_poll_checker #(
  parameter int ADDR_W = 24,
  parameter int GAP_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [GAP_W-1:0]  gap_cycles,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic              rd_req,
  input logic              rd_ack,
  input logic [ADDR_W-1:0] rd_addr
);
  logic [GAP_W-1:0] gap_l;
  logic             seen_hs;
  logic [31:0]      since_hs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_l    <= '0;
      seen_hs  <= 1'b0;
      since_hs <= '0;
    end else begin
      if (start && !busy) begin
        gap_l   <= gap_cycles;
        seen_hs <= 1'b0;
      end else if (rd_req && rd_ack) begin
        seen_hs <= 1'b1;
      end
      if (rd_req && rd_ack) since_hs <= '0;
      else if (since_hs != 32'hFFFF_FFFF) since_hs <= since_hs + 32'd1;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> $stable(rd_addr)); // R2
  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy); // R1
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R1
  AST_GAP_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) && seen_hs |-> since_hs == 32'(gap_l) + 32'd1); // R8
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail)); // R9
  AST_OUTCOME_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pass || fail) |-> done); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
endmodule

bind fpc_poll_ctrl fpc_poll_checker #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .gap_cycles(gap_cycles),
  .busy      (busy),
  .done      (done),
  .pass      (pass),
  .fail      (fail),
  .rd_req    (rd_req),
  .rd_ack    (rd_ack),
  .rd_addr   (rd_addr)
);

// File: tb/fpc_poll_ctrl_test.sv
module fpc_poll_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;
  localparam int GAP_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic op_is_erase = 1'b0;
  logic expect_msb = 1'b0;
  logic [ADDR_W-1:0] poll_addr = '0;
  logic [GAP_W-1:0] gap_cycles = '0;
  logic busy, done, pass, fail, rd_req, rd_ack;
  logic [DATA_W-1:0] final_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data = '0;

  int errors = 0;
  int checks = 0;

  // memory model state
  logic [7:0]  resp [0:15];
  int          lat = 0;
  int          base_idx = 0;
  int          hs_cnt = 0;
  int          wcnt = 0;
  int          cyc = 0;
  int          hs_cyc [0:63];
  logic [ADDR_W-1:0] hs_addr [0:63];

  // operation results
  logic got_pass, got_fail, got_done;
  logic [DATA_W-1:0] got_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpc_poll_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_W(GAP_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_is_erase(op_is_erase),
    .expect_msb(expect_msb), .poll_addr(poll_addr), .gap_cycles(gap_cycles),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .final_data(final_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data)
  );

  assign rd_ack = rd_req && (wcnt >= lat);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_req && rd_ack) begin
      rd_data <= resp[(hs_cnt - base_idx) & 15];
      hs_addr[hs_cnt & 63] <= rd_addr;
      hs_cyc[hs_cnt & 63]  <= cyc;
      hs_cnt <= hs_cnt + 1;
      wcnt <= 0;
    end else if (rd_req) begin
      wcnt <= wcnt + 1;
    end else begin
      wcnt <= 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_resp(input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] c, input logic [7:0] d);
    for (int i = 0; i < 16; i++) resp[i] = 8'hEE;
    resp[0] = a; resp[1] = b; resp[2] = c; resp[3] = d;
  endtask

  task automatic start_op(input logic erase, input logic msb,
                          input logic [ADDR_W-1:0] addr, input logic [GAP_W-1:0] gap);
    @(negedge clk);
    base_idx    = hs_cnt;
    op_is_erase = erase;
    expect_msb  = msb;
    poll_addr   = addr;
    gap_cycles  = gap;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after start", busy, 1'b1);
  endtask

  task automatic wait_done();
    got_done = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin
        got_done = 1'b1;
        break;
      end
      @(negedge clk);
    end
    got_pass = pass;
    got_fail = fail;
    got_data = final_data;
    chk("R9 done seen", got_done, 1'b1);
    chk("R9 busy low with done", busy, 1'b0);
    @(negedge clk);
    chk("R9 done one cycle", done, 1'b0);
  endtask

  task automatic chk_addrs(input string req, input logic [ADDR_W-1:0] addr);
    int bad = 0;
    for (int i = base_idx; i < hs_cnt; i++)
      if (hs_addr[i & 63] !== addr) bad++;
    chk(req, bad, 0);
  endtask

  task automatic t_reset();
    chk("R9 reset busy", busy, 1'b0);
    chk("R9 reset done", done, 1'b0);
    chk("R2 reset rd_req", rd_req, 1'b0);
  endtask

  task automatic t_first_match();
    lat = 0;
    set_resp(8'h80, 8'hA5, 8'h00, 8'h00);
    start_op(1'b0, 1'b1, 24'h012345, 8'd0);
    wait_done();
    chk("R4 pass", got_pass, 1'b1);
    chk("R4 final data from extra read", got_data, 8'hA5);
    chk("R4 read count", hs_cnt - base_idx, 2);
    chk_addrs("R2 address", 24'h012345);
  endtask

  task automatic t_poll_loop();
    lat = 0;
    set_resp(8'h92, 8'h92, 8'h12, 8'h34);
    start_op(1'b0, 1'b0, 24'h000777, 8'd0);
    wait_done();
    chk("R5 pass after loops", got_pass, 1'b1);
    chk("R5 read count", hs_cnt - base_idx, 4);
    chk("R5 final data", got_data, 8'h34);
  endtask

  task automatic t_erase();
    lat = 1;
    set_resp(8'h08, 8'h80, 8'hFF, 8'h00);
    start_op(1'b1, 1'b0, 24'h3F0000, 8'd0);
    wait_done();
    chk("R3 erase expects 1", got_pass, 1'b1);
    chk("R3 erase read count", hs_cnt - base_idx, 3);
    chk("R3 erase final data", got_data, 8'hFF);
  endtask

  task automatic t_recheck_pass();
    lat = 0;
    set_resp(8'hA0, 8'h55, 8'h56, 8'h00);
    start_op(1'b0, 1'b0, 24'h000100, 8'd0);
    wait_done();
    chk("R6 pass on recheck", got_pass, 1'b1);
    chk("R6 fail low", got_fail, 1'b0);
    chk("R6 read count", hs_cnt - base_idx, 3);
    chk("R6 final data", got_data, 8'h56);
  endtask

  task automatic t_recheck_fail();
    int n;
    lat = 0;
    set_resp(8'hA0, 8'hA4, 8'h00, 8'h00);
    start_op(1'b0, 1'b0, 24'h000200, 8'd0);
    wait_done();
    chk("R7 fail", got_fail, 1'b1);
    chk("R7 pass low", got_pass, 1'b0);
    chk("R7 final data is recheck word", got_data, 8'hA4);
    n = hs_cnt - base_idx;
    chk("R7 read count", n, 2);
    repeat (10) @(negedge clk);
    chk("R7 no reads after fail", hs_cnt - base_idx, 2);
    chk("R7 idle after fail", busy, 1'b0);
  endtask

  task automatic t_bit5_ignored();
    lat = 0;
    set_resp(8'hA0, 8'h81, 8'h00, 8'h00);
    start_op(1'b0, 1'b1, 24'h000300, 8'd0);
    wait_done();
    chk("R10 pass despite bit 5", got_pass, 1'b1);
    chk("R10 read count", hs_cnt - base_idx, 2);
    chk("R10 final data", got_data, 8'h81);
  endtask

  task automatic t_gap();
    int bad;
    lat = 0;
    set_resp(8'h00, 8'h00, 8'h80, 8'h81);
    start_op(1'b0, 1'b1, 24'h000400, 8'd3);
    wait_done();
    chk("R8 read count gap 3", hs_cnt - base_idx, 4);
    bad = 0;
    for (int i = base_idx + 1; i < hs_cnt; i++)
      if (hs_cyc[i & 63] - hs_cyc[(i - 1) & 63] != 5) bad++;
    chk("R8 spacing gap 3", bad, 0);

    lat = 2;
    set_resp(8'h00, 8'h80, 8'hC1, 8'h00);
    start_op(1'b0, 1'b1, 24'h000500, 8'd2);
    wait_done();
    chk("R8 read count gap 2", hs_cnt - base_idx, 3);
    bad = 0;
    for (int i = base_idx + 1; i < hs_cnt; i++)
      if (hs_cyc[i & 63] - hs_cyc[(i - 1) & 63] != 6) bad++;
    chk("R8 spacing gap 2 latency 2", bad, 0);
    chk("R2 final with wait states", got_data, 8'hC1);
    chk_addrs("R2 address with wait states", 24'h000500);
  endtask

  task automatic t_start_busy();
    lat = 3;
    set_resp(8'h80, 8'h00, 8'h42, 8'h00);
    start_op(1'b0, 1'b0, 24'h00ABCD, 8'd1);
    @(negedge clk);
    op_is_erase = 1'b1;
    expect_msb  = 1'b1;
    poll_addr   = 24'h111111;
    gap_cycles  = 8'd0;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R1 outcome unchanged", got_pass, 1'b1);
    chk("R1 read count unchanged", hs_cnt - base_idx, 3);
    chk("R1 final data", got_data, 8'h42);
    chk_addrs("R1 address unchanged", 24'h00ABCD);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_first_match();
    t_poll_loop();
    t_erase();
    t_recheck_pass();
    t_recheck_fail();
    t_bit5_ignored();
    t_gap();
    t_start_busy();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (R9 completion): actual=timeout expected=done");
    summary();
    $finish;
  end
endmodule